// File: doc/BRIEF.md
# DMA Channel Event Latch with Miss Detection

This block holds the per-channel event state of a 64-channel DMA controller. Each channel has an external synchronization input that pulses for one cycle. Every pulse sets the channel's event bit, even when the channel is disabled. A channel counts as pending for transfer-request submission only while both its event bit and its enable bit are 1. The block presents those pending channels as a vector, together with a single flag that is high when any channel is pending.

A downstream prioritizer returns a 64-bit service-clear vector, and each 1 in it clears the matching event bit. Software can also clear event bits by writing 1s through a 32-bit register port. A pulse that arrives on an enabled channel whose event bit is already set means an event has been lost, and this is recorded in a miss register. A set always beats a clear on the same channel in the same cycle, and in that case the loss is still recorded. Every 64-bit quantity is reached as two 32-bit words: channels 0 to 31 at the lower address and channels 32 to 63 at the next one.

Top module: `dma_evt_capture`

## Requirements
- R1: A synchronous active-high reset clears every event, enable and miss bit, so `pend_evt`, `evt_active` and every register read are 0 afterwards.
- R2: A 1 on `ext_evt[c]` sets the event bit of channel c at that clock edge, whatever the channel's enable bit is.
- R3: `pend_evt[c]` is 1 exactly when channel c has both its event bit and its enable bit set. `evt_active` is 1 exactly when `pend_evt` is non-zero.
- R4: A 1 on `svc_clr[c]` clears the event bit of channel c when no event arrives on c in the same cycle.
- R5: Writing a word to the event-clear addresses clears the event bits where the data holds 1s. Bits written as 0 leave their event bits unchanged.
- R6: When a set and a clear (service or software) hit the same channel in the same cycle, the event bit ends at 1. A miss is recorded only if the event bit was already 1 and the channel is enabled.
- R7: An event on a channel whose event bit is already 1 sets that channel's miss bit only when its enable bit is 1.
- R8: Writing 1s to the miss-clear addresses clears the matching miss bits, and writing 0s has no effect. If a miss is set and cleared on the same channel in the same cycle, the miss bit ends at 1.
- R9: The enable words read back the value last written. The event-clear and miss-clear addresses read back as 0, as do the unused addresses 10 to 15. Writes to the event and miss addresses are ignored.
- R10: The word address is 2 × group + half. The groups are event (0), enable (1), event-clear (2), miss (3) and miss-clear (4). Half 0 holds channels 0–31 and half 1 holds channels 32–63, with channel c at bit c mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt | input | 64 | One-cycle event pulses, one per channel |
| svc_clr | input | 64 | Serviced-channel clears from the prioritizer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pend_evt | output | 64 | Channels with event and enable both set |
| evt_active | output | 1 | High when any channel is pending |

## Verification
The assertions assume that `ext_evt` and `svc_clr` are sampled only at the clock edge and are driven low while reset is held, so that no event is lost inside the reset window. They also assume that a register write lasts a single cycle. The bench drives every input for exactly one cycle after each edge, keeps the inputs at zero during reset and between reads, and reads registers only while the inputs are idle, so that reading never changes state.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  // Register groups; the word address is group * words_per_group + half.
  typedef enum logic [2:0] {
    GRP_EVT  = 3'd0,
    GRP_ENA  = 3'd1,
    GRP_ECLR = 3'd2,
    GRP_MISS = 3'd3,
    GRP_MCLR = 3'd4
  } reg_grp_e;

  function automatic int word_index(reg_grp_e g, int half, int halves);
    return int'(g) * halves + half;
  endfunction

  // Event bit update: a set overrides any clear.
  function automatic logic evt_next(logic cur, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  // A lost event needs an enabled channel whose event bit is already set.
  function automatic logic lost_event(logic set, logic cur, logic ena);
    return set & cur & ena;
  endfunction

  // Miss bit update: recording a loss overrides a clear.
  function automatic logic miss_next(logic cur, logic lost, logic clr);
    return lost ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/dma_evt_cell.sv
module dma_evt_cell
  import dma_evt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_in,
  input  logic svc_clr,
  input  logic sw_clr,
  input  logic ena_we,
  input  logic ena_wd,
  input  logic miss_clr,
  output logic evt_q,
  output logic ena_q,
  output logic miss_q,
  output logic miss_hit
);

  logic any_clr;
  logic evt_d;
  logic miss_d;
  logic ena_d;

  assign any_clr  = svc_clr | sw_clr;
  assign miss_hit = lost_event(ev_in, evt_q, ena_q);
  assign evt_d    = evt_next(evt_q, ev_in, any_clr);
  assign miss_d   = miss_next(miss_q, miss_hit, miss_clr);
  assign ena_d    = ena_we ? ena_wd : ena_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q  <= 1'b0;
      ena_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      ena_q  <= ena_d;
      miss_q <= miss_d;
    end
  end

endmodule

// File: rtl/dma_evt_bank.sv
module dma_evt_bank #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_in,
  input  logic [NUM_CH-1:0] svc_clr,
  input  logic [NUM_CH-1:0] sw_clr,
  input  logic [NUM_CH-1:0] ena_we,
  input  logic [NUM_CH-1:0] ena_wd,
  input  logic [NUM_CH-1:0] miss_clr,
  output logic [NUM_CH-1:0] evt_q,
  output logic [NUM_CH-1:0] ena_q,
  output logic [NUM_CH-1:0] miss_q,
  output logic [NUM_CH-1:0] miss_hit,
  output logic [NUM_CH-1:0] pend,
  output logic              active
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_evt_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .ev_in    (ev_in[c]),
      .svc_clr  (svc_clr[c]),
      .sw_clr   (sw_clr[c]),
      .ena_we   (ena_we[c]),
      .ena_wd   (ena_wd[c]),
      .miss_clr (miss_clr[c]),
      .evt_q    (evt_q[c]),
      .ena_q    (ena_q[c]),
      .miss_q   (miss_q[c]),
      .miss_hit (miss_hit[c])
    );
  end

  assign pend   = evt_q & ena_q;
  assign active = |pend;

endmodule

// File: rtl/dma_evt_regif.sv
module dma_evt_regif
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [NUM_CH-1:0] evt_q,
  input  logic [NUM_CH-1:0] ena_q,
  input  logic [NUM_CH-1:0] miss_q,
  output logic [NUM_CH-1:0] ena_we,
  output logic [NUM_CH-1:0] ena_wd,
  output logic [NUM_CH-1:0] sw_clr,
  output logic [NUM_CH-1:0] miss_clr
);

  localparam int HALVES = NUM_CH / WORD_W;

  function automatic logic [ADDR_W-1:0] adr(reg_grp_e g, int half);
    return ADDR_W'(word_index(g, half, HALVES));
  endfunction

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic hit_ena, hit_eclr, hit_mclr;
    assign hit_ena  = wr && (addr == adr(GRP_ENA, h));
    assign hit_eclr = wr && (addr == adr(GRP_ECLR, h));
    assign hit_mclr = wr && (addr == adr(GRP_MCLR, h));

    assign ena_we  [h*WORD_W +: WORD_W] = {WORD_W{hit_ena}};
    assign ena_wd  [h*WORD_W +: WORD_W] = wdata;
    assign sw_clr  [h*WORD_W +: WORD_W] = hit_eclr ? wdata : '0;
    assign miss_clr[h*WORD_W +: WORD_W] = hit_mclr ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (addr == adr(GRP_EVT, h))  rdata = evt_q [h*WORD_W +: WORD_W];
      if (addr == adr(GRP_ENA, h))  rdata = ena_q [h*WORD_W +: WORD_W];
      if (addr == adr(GRP_MISS, h)) rdata = miss_q[h*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/dma_evt_capture.sv
module dma_evt_capture #(
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ext_evt,
  input  logic [NUM_CH-1:0] svc_clr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pend_evt,
  output logic              evt_active
);

  // Named internal state and strobes, brought out for the checker.
  logic [NUM_CH-1:0] evt_vec;
  logic [NUM_CH-1:0] ena_vec;
  logic [NUM_CH-1:0] miss_vec;
  logic [NUM_CH-1:0] miss_hit_vec;
  logic [NUM_CH-1:0] ena_we_vec;
  logic [NUM_CH-1:0] ena_wd_vec;
  logic [NUM_CH-1:0] sw_clr_vec;
  logic [NUM_CH-1:0] miss_clr_vec;

  dma_evt_regif #(
    .NUM_CH (NUM_CH),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_regif (
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .evt_q    (evt_vec),
    .ena_q    (ena_vec),
    .miss_q   (miss_vec),
    .ena_we   (ena_we_vec),
    .ena_wd   (ena_wd_vec),
    .sw_clr   (sw_clr_vec),
    .miss_clr (miss_clr_vec)
  );

  dma_evt_bank #(
    .NUM_CH (NUM_CH)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ev_in    (ext_evt),
    .svc_clr  (svc_clr),
    .sw_clr   (sw_clr_vec),
    .ena_we   (ena_we_vec),
    .ena_wd   (ena_wd_vec),
    .miss_clr (miss_clr_vec),
    .evt_q    (evt_vec),
    .ena_q    (ena_vec),
    .miss_q   (miss_vec),
    .miss_hit (miss_hit_vec),
    .pend     (pend_evt),
    .active   (evt_active)
  );

endmodule

// File: rtl/dma_evt_checker.sv
module dma_evt_checker #(
  parameter int NUM_CH = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ext_evt,
  input logic [NUM_CH-1:0] svc_clr,
  input logic [NUM_CH-1:0] sw_clr,
  input logic [NUM_CH-1:0] miss_clr,
  input logic [NUM_CH-1:0] miss_hit,
  input logic [NUM_CH-1:0] evt_q,
  input logic [NUM_CH-1:0] ena_q,
  input logic [NUM_CH-1:0] miss_q,
  input logic [NUM_CH-1:0] pend_evt,
  input logic              evt_active
);

  p_reset_clean_r1: assert property (@(posedge clk)
    $past(rst) |-> (evt_q == '0 && ena_q == '0 && miss_q == '0));

  p_set_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (ext_evt != '0) |=> ((evt_q & $past(ext_evt)) == $past(ext_evt)));

  p_pend_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_evt & ~(evt_q & ena_q)) == '0);

  p_active_flag_r3: assert property (@(posedge clk) disable iff (rst)
    ((evt_q & ena_q) != '0) |-> evt_active);

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
    ((svc_clr | sw_clr) & ~ext_evt) != '0
      |=> ((evt_q & $past((svc_clr | sw_clr) & ~ext_evt)) == '0));

  p_miss_cause_r7: assert property (@(posedge clk) disable iff (rst)
    ((miss_q & ~$past(miss_q)) & ~$past(ext_evt & evt_q & ena_q)) == '0);

  p_miss_record_r7: assert property (@(posedge clk) disable iff (rst)
    (miss_hit != '0) |=> ((miss_q & $past(miss_hit)) == $past(miss_hit)));

  p_miss_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (miss_clr & ~miss_hit) != '0
      |=> ((miss_q & $past(miss_clr & ~miss_hit)) == '0));

endmodule

bind dma_evt_capture dma_evt_checker #(.NUM_CH(NUM_CH)) u_dma_evt_checker (
  .clk        (clk),
  .rst        (rst),
  .ext_evt    (ext_evt),
  .svc_clr    (svc_clr),
  .sw_clr     (sw_clr_vec),
  .miss_clr   (miss_clr_vec),
  .miss_hit   (miss_hit_vec),
  .evt_q      (evt_vec),
  .ena_q      (ena_vec),
  .miss_q     (miss_vec),
  .pend_evt   (pend_evt),
  .evt_active (evt_active)
);

// File: tb/test_dma_evt_capture.sv
`timescale 1ns/1ps
module test_dma_evt_capture;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] ext_evt = '0;
  logic [63:0] svc_clr = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pend_evt;
  logic        evt_active;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  // Bench-side state, built from the requirements.
  logic [63:0] m_evt = '0, m_ena = '0, m_miss = '0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  dma_evt_capture i_dma_evt_capture (
    .clk(clk), .rst(rst), .ext_evt(ext_evt), .svc_clr(svc_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pend_evt(pend_evt), .evt_active(evt_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // Expected read value: address = 2*group + half (R10).
  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [63:0] src;
    case (a[3:1])
      3'd0:    src = m_evt;
      3'd1:    src = m_ena;
      3'd3:    src = m_miss;
      default: src = '0;
    endcase
    if (a >= 4'd10) src = '0;
    return a[0] ? src[63:32] : src[31:0];
  endfunction

  task automatic step(input logic [63:0] ev, input logic [63:0] sc,
                      input logic we, input logic [3:0] a, input logic [31:0] d);
    logic [63:0] wide, eclr, mclr, n_evt, n_ena, n_miss;
    ext_evt = ev; svc_clr = sc; reg_wr = we; reg_addr = a; reg_wdata = d;
    wide = a[0] ? {d, 32'h0} : {32'h0, d};
    eclr = (we && (a == 4'd4 || a == 4'd5)) ? wide : '0;
    mclr = (we && (a == 4'd8 || a == 4'd9)) ? wide : '0;
    n_ena = m_ena;
    if (we && a == 4'd2) n_ena[31:0]  = d;
    if (we && a == 4'd3) n_ena[63:32] = d;
    for (int c = 0; c < 64; c++) begin
      n_evt[c] = m_evt[c];
      if (sc[c] || eclr[c]) n_evt[c] = 1'b0;
      if (ev[c]) n_evt[c] = 1'b1;
      n_miss[c] = m_miss[c];
      if (mclr[c]) n_miss[c] = 1'b0;
      if (ev[c] && m_evt[c] && m_ena[c]) n_miss[c] = 1'b1;
    end
    @(posedge clk);
    m_evt = n_evt; m_ena = n_ena; m_miss = n_miss;
    #1;
    ext_evt = '0; svc_clr = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk_out(input string req);
    chk(req, pend_evt, m_evt & m_ena);
    chk(req, {63'h0, evt_active}, {63'h0, |(m_evt & m_ena)});
  endtask

  task automatic chk_word(input string req, input logic [3:0] a);
    reg_addr = a;
    #1;
    chk(req, {32'h0, reg_rdata}, {32'h0, exp_read(a)});
  endtask

  task automatic chk_all(input string req);
    for (int a = 0; a < 16; a++) chk_word(req, 4'(a));
    chk_out(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk_all("R1");

    // R2 / R10 / R5: sweep every channel with enables off.
    for (int c = 0; c < 64; c++) begin
      logic [63:0] b;
      logic [3:0]  ea, ca;
      b  = 64'd1 << c;
      ea = (c < 32) ? 4'd0 : 4'd1;
      ca = (c < 32) ? 4'd4 : 4'd5;
      step(b, '0, 1'b0, 4'd0, '0);
      chk_word("R2", ea);
      chk_word("R10", ea);
      chk_out("R3");
      step('0, '0, 1'b1, ca, ~exp_read(ea));
      chk_word("R5", ea);
      step('0, '0, 1'b1, ca, 32'd1 << (c % 32));
      chk_word("R5", ea);
    end

    // R9: enable readback, write-only and read-only addresses.
    step('0, '0, 1'b1, 4'd2, 32'hA5A5_5A5A);
    step('0, '0, 1'b1, 4'd3, 32'h0F0F_F0F0);
    step('0, '0, 1'b1, 4'd0, 32'hFFFF_FFFF);
    step('0, '0, 1'b1, 4'd7, 32'hFFFF_FFFF);
    chk_all("R9");

    // R3: mixed event pattern against the enables.
    step(64'hFFFF_0000_FFFF_0000, '0, 1'b0, 4'd0, '0);
    chk_all("R3");

    // R4: service clear of everything.
    step('0, '1, 1'b0, 4'd0, '0);
    chk_all("R4");
    chk_out("R4");

    // R7: enabled low half, disabled high half, repeat events.
    step('0, '0, 1'b1, 4'd2, 32'hFFFF_FFFF);
    step('0, '0, 1'b1, 4'd3, 32'h0);
    step(64'h0000_000F_0000_000F, '0, 1'b0, 4'd0, '0);
    step(64'h0000_000F_0000_000F, '0, 1'b0, 4'd0, '0);
    chk_all("R7");

    // R8: clear misses, then miss set against miss clear.
    step('0, '0, 1'b1, 4'd8, 32'hFFFF_FFFF);
    chk_all("R8");

    // R6: set and service clear collide; bits 0..3 already set.
    step(64'hFF, 64'hFF, 1'b0, 4'd0, '0);
    chk_all("R6");
    // R6: set and software clear collide on a clear channel.
    step(64'h100, '0, 1'b1, 4'd4, 32'h100);
    chk_all("R6");

    step(64'h1, '0, 1'b1, 4'd8, 32'h1);
    chk_all("R8");
    step('0, '0, 1'b1, 4'd8, 32'h0);
    chk_word("R8", 4'd6);
    step('0, '0, 1'b1, 4'd8, 32'hF);
    chk_word("R8", 4'd6);

    // Pseudo-random sweep covering every address and sparse traffic.
    for (int i = 0; i < 600; i++) begin
      logic [63:0] ev, sc, r;
      ev = nxt_rand() & nxt_rand() & nxt_rand();
      sc = nxt_rand() & nxt_rand() & nxt_rand();
      r  = nxt_rand();
      step(ev, sc, r[0], 4'(r[9:4] % 10), r[63:32]);
      chk_out("R3");
      if (i % 40 == 39) chk_all("R10");
    end

    // R1: reset in mid-run.
    rst = 1'b1;
    @(posedge clk);
    m_evt = '0; m_ena = '0; m_miss = '0;
    #1 rst = 1'b0;
    chk_all("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule